// File: doc/BRIEF.md
# Instruction Control Decoder

This block turns the opcode-class, function and destination-register fields of a 32-bit load/store instruction word into the control lines that steer a single-cycle datapath. It is purely combinational: the fields go in, and the controls settle in the same cycle. It covers register-to-register and immediate arithmetic and logic (add, subtract, and, or, exclusive-or), word and byte loads, word stores, and relative branches.

Three controls change architectural state: register write, memory write and next-PC select. The decoder does not drive these directly. It produces unconditioned "intent" versions of them, and a separate condition stage, outside this block, gates them with the instruction's condition code. Flag storage and condition evaluation are also outside this block. The flag-write mask is a 2-bit field. Its upper bit enables the negative/zero pair and its lower bit enables the carry/overflow pair.

The block has no streaming data path, so every pin is a plain level signal with no handshake.

Top module: `instr_ctl_decoder`

## Requirements
- R1: For class `op`=00 (data processing) with a supported command, the register-write intent is 1. The memory-write intent, memory-to-register select, both register-source selects and the byte select are 0. The ALU source equals `funct[5]`, and the immediate format is 00.
- R2: In data processing, the command `funct[4:1]` sets the ALU control as follows: 0100→000 (add), 0010→001 (subtract), 0000→010 (and), 1100→011 (or), 0001→100 (exclusive-or).
- R3: The flag mask is 00 whenever `funct[0]` (S) is clear, and also for any class other than data processing. When S is set, it is 11 for add/subtract and 10 for and/or/exclusive-or.
- R4: For class `op`=01 with `funct[0]`=1 and `funct[2]`=0 (word load), the outputs are: register-write intent 1, memory-to-register 1, ALU source 1, immediate format 01, byte select 0, memory-write intent 0.
- R5: A load with `funct[2]`=1 (byte load) matches R4 except that the byte select is 1.
- R6: For class `op`=01 with `funct[0]`=0 (store), the outputs are: memory-write intent 1, register-write intent 0, second register source taken from Rd (select 1), immediate format 01, ALU source 1. The byte select stays 0 even when `funct[2]`=1.
- R7: For class `op`=10 (branch), the outputs are: PC-source intent 1, first register source is the PC (select 1), immediate format 10, ALU source 1. The register-write and memory-write intents are 0.
- R8: Memory and branch classes force the ALU control to 000 (add) and the flag mask to 00, whatever the function bits are.
- R9: The PC-source intent is 1 for a supported data-processing instruction whose Rd is 15. It stays 0 for other Rd values and for loads into register 15.
- R10: Class `op`=11, or a data-processing command outside the R2 list, sets the register-write, memory-write and PC-source intents and the flag mask to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 2 | Instruction class field |
| funct_i | input | 6 | Function field (immediate flag, command or load/store bits, S/L bit) |
| rd_i | input | 4 | Destination register number |
| reg_src_n_pc_o | output | 1 | First register read port takes the PC |
| reg_src_m_rd_o | output | 1 | Second register read port takes Rd (store data) |
| imm_sel_o | output | 2 | Immediate format: 00 data-proc, 01 memory, 10 branch |
| alu_src_imm_o | output | 1 | ALU second operand is the extended immediate |
| mem_to_reg_o | output | 1 | Write-back value comes from memory |
| byte_acc_o | output | 1 | Memory read is a zero-extended byte |
| alu_ctrl_o | output | 3 | ALU operation code |
| flag_w_o | output | 2 | Flag-write mask (bit 1 NZ, bit 0 CV) |
| reg_w_int_o | output | 1 | Unconditioned register-write intent |
| mem_w_int_o | output | 1 | Unconditioned memory-write intent |
| pc_src_int_o | output | 1 | Unconditioned next-PC-from-result intent |

## Verification
The embedded checks assume that the input fields are always 0 or 1 and never unknown. They also assume that the output cross-relations only need to hold after the combinational logic has settled, so they are written as immediate checks evaluated whenever the fields change. The stimulus meets these assumptions by driving fully defined fields one instruction at a time, on one clock edge, and sampling on the opposite edge. Unsupported commands and the reserved class are driven on purpose to exercise the zeroed-intent path.

// File: rtl/idec_pkg.sv
package idec_pkg;

  typedef enum logic [1:0] {
    OPC_DP  = 2'b00,
    OPC_MEM = 2'b01,
    OPC_BR  = 2'b10,
    OPC_RSV = 2'b11
  } op_cls_e;

  typedef enum logic [3:0] {
    CMD_AND = 4'b0000,
    CMD_EOR = 4'b0001,
    CMD_SUB = 4'b0010,
    CMD_ADD = 4'b0100,
    CMD_ORR = 4'b1100
  } dp_cmd_e;

  typedef enum logic [2:0] {
    ALU_ADD = 3'd0,
    ALU_SUB = 3'd1,
    ALU_AND = 3'd2,
    ALU_ORR = 3'd3,
    ALU_EOR = 3'd4
  } alu_fn_e;

  typedef enum logic [1:0] {
    IMM_DP  = 2'b00,
    IMM_MEM = 2'b01,
    IMM_BR  = 2'b10
  } imm_fmt_e;

  localparam logic [1:0] FLAGS_NONE  = 2'b00;
  localparam logic [1:0] FLAGS_NZ    = 2'b10;
  localparam logic [1:0] FLAGS_NZCV  = 2'b11;

endpackage

// File: rtl/idec_class.sv
// Instruction-class decoder: class-wide steering and raw intents.
module idec_class
  import idec_pkg::*;
(
  input  logic [1:0] op_i,
  input  logic       imm_bit_i,
  input  logic       byte_bit_i,
  input  logic       ld_bit_i,
  output logic       is_dp_o,
  output logic       is_br_o,
  output logic       is_ld_o,
  output logic       is_st_o,
  output logic       reg_w_o,
  output logic       mem_w_o,
  output logic       mem_to_reg_o,
  output logic       alu_src_imm_o,
  output logic [1:0] imm_sel_o,
  output logic       src_n_pc_o,
  output logic       src_m_rd_o,
  output logic       byte_acc_o,
  output logic       force_add_o
);

  always_comb begin
    is_dp_o       = 1'b0;
    is_br_o       = 1'b0;
    is_ld_o       = 1'b0;
    is_st_o       = 1'b0;
    reg_w_o       = 1'b0;
    mem_w_o       = 1'b0;
    mem_to_reg_o  = 1'b0;
    alu_src_imm_o = 1'b0;
    imm_sel_o     = IMM_DP;
    src_n_pc_o    = 1'b0;
    src_m_rd_o    = 1'b0;
    byte_acc_o    = 1'b0;
    force_add_o   = 1'b0;
    unique case (op_i)
      OPC_DP: begin
        is_dp_o       = 1'b1;
        reg_w_o       = 1'b1;
        alu_src_imm_o = imm_bit_i;
      end
      OPC_MEM: begin
        force_add_o   = 1'b1;
        alu_src_imm_o = 1'b1;
        imm_sel_o     = IMM_MEM;
        if (ld_bit_i) begin
          is_ld_o      = 1'b1;
          reg_w_o      = 1'b1;
          mem_to_reg_o = 1'b1;
          byte_acc_o   = byte_bit_i;
        end else begin
          is_st_o    = 1'b1;
          mem_w_o    = 1'b1;
          src_m_rd_o = 1'b1;
        end
      end
      OPC_BR: begin
        is_br_o       = 1'b1;
        force_add_o   = 1'b1;
        alu_src_imm_o = 1'b1;
        imm_sel_o     = IMM_BR;
        src_n_pc_o    = 1'b1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/idec_alu.sv
// ALU-operation decoder with flag-write mask.
module idec_alu
  import idec_pkg::*;
#(
  parameter int CMD_W = 4,
  parameter int AC_W  = 3,
  parameter int FW_W  = 2
) (
  input  logic             is_dp_i,
  input  logic             force_add_i,
  input  logic [CMD_W-1:0] cmd_i,
  input  logic             s_bit_i,
  output logic [AC_W-1:0]  alu_ctrl_o,
  output logic [FW_W-1:0]  flag_w_o,
  output logic             cmd_ok_o
);

  logic [AC_W-1:0] fn;
  logic            arith;

  always_comb begin
    fn       = AC_W'(ALU_ADD);
    arith    = 1'b0;
    cmd_ok_o = 1'b1;
    unique case (cmd_i)
      CMD_ADD: begin fn = AC_W'(ALU_ADD); arith = 1'b1; end
      CMD_SUB: begin fn = AC_W'(ALU_SUB); arith = 1'b1; end
      CMD_AND: fn = AC_W'(ALU_AND);
      CMD_ORR: fn = AC_W'(ALU_ORR);
      CMD_EOR: fn = AC_W'(ALU_EOR);
      default: cmd_ok_o = 1'b0;
    endcase
  end

  always_comb begin
    alu_ctrl_o = AC_W'(ALU_ADD);
    flag_w_o   = FW_W'(FLAGS_NONE);
    if (is_dp_i && !force_add_i) begin
      alu_ctrl_o = fn;
      if (s_bit_i && cmd_ok_o)
        flag_w_o = arith ? FW_W'(FLAGS_NZCV) : FW_W'(FLAGS_NZ);
    end
  end

endmodule

// File: rtl/idec_pcsel.sv
// Next-PC intent: branches, or data-processing results aimed at the PC register.
module idec_pcsel #(
  parameter int RD_W   = 4,
  parameter int PC_IDX = 15
) (
  input  logic            is_br_i,
  input  logic            is_dp_i,
  input  logic            reg_w_i,
  input  logic [RD_W-1:0] rd_i,
  output logic            pc_src_o
);

  localparam logic [RD_W-1:0] PC_SEL = RD_W'(PC_IDX);

  always_comb pc_src_o = is_br_i | (is_dp_i & reg_w_i & (rd_i == PC_SEL));

endmodule

// File: rtl/instr_ctl_decoder.sv
module instr_ctl_decoder
  import idec_pkg::*;
#(
  parameter int RD_W   = 4,
  parameter int PC_IDX = 15
) (
  input  logic [1:0]      op_i,
  input  logic [5:0]      funct_i,
  input  logic [RD_W-1:0] rd_i,
  output logic            reg_src_n_pc_o,
  output logic            reg_src_m_rd_o,
  output logic [1:0]      imm_sel_o,
  output logic            alu_src_imm_o,
  output logic            mem_to_reg_o,
  output logic            byte_acc_o,
  output logic [2:0]      alu_ctrl_o,
  output logic [1:0]      flag_w_o,
  output logic            reg_w_int_o,
  output logic            mem_w_int_o,
  output logic            pc_src_int_o
);

  localparam int CMD_W = 4;
  localparam logic [RD_W-1:0] PC_SEL = RD_W'(PC_IDX);

  logic is_dp, is_br, is_ld, is_st, raw_reg_w, force_add, cmd_ok;

  idec_class u_class (
    .op_i         (op_i),
    .imm_bit_i    (funct_i[5]),
    .byte_bit_i   (funct_i[2]),
    .ld_bit_i     (funct_i[0]),
    .is_dp_o      (is_dp),
    .is_br_o      (is_br),
    .is_ld_o      (is_ld),
    .is_st_o      (is_st),
    .reg_w_o      (raw_reg_w),
    .mem_w_o      (mem_w_int_o),
    .mem_to_reg_o (mem_to_reg_o),
    .alu_src_imm_o(alu_src_imm_o),
    .imm_sel_o    (imm_sel_o),
    .src_n_pc_o   (reg_src_n_pc_o),
    .src_m_rd_o   (reg_src_m_rd_o),
    .byte_acc_o   (byte_acc_o),
    .force_add_o  (force_add)
  );

  idec_alu #(.CMD_W(CMD_W), .AC_W(3), .FW_W(2)) u_alu (
    .is_dp_i    (is_dp),
    .force_add_i(force_add),
    .cmd_i      (funct_i[CMD_W:1]),
    .s_bit_i    (funct_i[0]),
    .alu_ctrl_o (alu_ctrl_o),
    .flag_w_o   (flag_w_o),
    .cmd_ok_o   (cmd_ok)
  );

  always_comb reg_w_int_o = raw_reg_w & (~is_dp | cmd_ok);

  idec_pcsel #(.RD_W(RD_W), .PC_IDX(PC_IDX)) u_pc (
    .is_br_i (is_br),
    .is_dp_i (is_dp),
    .reg_w_i (reg_w_int_o),
    .rd_i    (rd_i),
    .pc_src_o(pc_src_int_o)
  );

  always_comb begin
    // R8
    if (is_ld || is_st || is_br)
      mem_br_add_chk: assert (alu_ctrl_o == ALU_ADD && flag_w_o == 2'b00);
    // R3
    if (flag_w_o != 2'b00)
      flagw_dp_only_chk: assert (op_i == OPC_DP && funct_i[0]);
    // R9
    if (pc_src_int_o)
      pcsrc_cause_chk: assert (is_br || (reg_w_int_o && !mem_to_reg_o && rd_i == PC_SEL));
    // R5
    if (byte_acc_o)
      byte_load_chk: assert (mem_to_reg_o && reg_w_int_o && !mem_w_int_o);
    // R1
    class_excl_chk: assert ($onehot0({mem_to_reg_o, mem_w_int_o, reg_src_n_pc_o}));
    // R10
    if (op_i == OPC_RSV)
      rsv_quiet_chk: assert (!reg_w_int_o && !mem_w_int_o && !pc_src_int_o);
  end

endmodule

// File: tb/instr_ctl_decoder_test.sv
module instr_ctl_decoder_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] op;
  logic [5:0] fn;
  logic [3:0] rd;
  logic       n_pc, m_rd, alu_imm, m2r, byte_a, rw, mw, pcs;
  logic [1:0] imm_sel, fw;
  logic [2:0] ac;

  int vectors = 0;
  int errors  = 0;

  always #2.5 clk = ~clk;

  instr_ctl_decoder uut (
    .op_i(op), .funct_i(fn), .rd_i(rd),
    .reg_src_n_pc_o(n_pc), .reg_src_m_rd_o(m_rd), .imm_sel_o(imm_sel),
    .alu_src_imm_o(alu_imm), .mem_to_reg_o(m2r), .byte_acc_o(byte_a),
    .alu_ctrl_o(ac), .flag_w_o(fw), .reg_w_int_o(rw), .mem_w_int_o(mw),
    .pc_src_int_o(pcs)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic [1:0] o, input logic [5:0] f, input logic [3:0] r);
    @(posedge clk);
    op = o; fn = f; rd = r;
    @(negedge clk);
  endtask

  // data-processing field: {I, cmd, S}
  function automatic logic [5:0] dpf(input logic i, input logic [3:0] c, input logic s);
    return {i, c, s};
  endfunction

  // memory field: {~I=0, P=1, U=1, B, W=0, L}
  function automatic logic [5:0] mf(input logic b, input logic l);
    return {1'b0, 1'b1, 1'b1, b, 1'b0, l};
  endfunction

  task automatic t_reset_state;
    rst = 1'b1;
    drive(2'b11, 6'h3f, 4'd15);
    chk("R10", "reserved reg_w", rw, 0);
    chk("R10", "reserved mem_w", mw, 0);
    chk("R10", "reserved pc_src", pcs, 0);
    chk("R10", "reserved flags", fw, 0);
    rst = 1'b0;
  endtask

  task automatic t_dp_ops;
    logic [3:0] cmds [5] = '{4'b0100, 4'b0010, 4'b0000, 4'b1100, 4'b0001};
    int         codes[5] = '{0, 1, 2, 3, 4};
    for (int k = 0; k < 5; k++) begin
      drive(2'b00, dpf(k[0], cmds[k], 1'b0), 4'd3);
      chk("R2", "alu_ctrl", ac, codes[k]);
      chk("R1", "reg_w", rw, 1);
      chk("R1", "alu_src", alu_imm, k % 2);
      chk("R1", "imm_sel", imm_sel, 0);
      chk("R1", "mem_w", mw, 0);
      chk("R1", "mem_to_reg", m2r, 0);
      chk("R1", "byte", byte_a, 0);
      chk("R1", "srcs", {n_pc, m_rd}, 0);
      chk("R3", "flags S=0", fw, 0);
      chk("R9", "pc_src rd3", pcs, 0);
    end
  endtask

  task automatic t_flags;
    drive(2'b00, dpf(1'b0, 4'b0100, 1'b1), 4'd1); chk("R3", "ADDS mask", fw, 3);
    drive(2'b00, dpf(1'b1, 4'b0010, 1'b1), 4'd1); chk("R3", "SUBS mask", fw, 3);
    drive(2'b00, dpf(1'b0, 4'b0000, 1'b1), 4'd1); chk("R3", "ANDS mask", fw, 2);
    drive(2'b00, dpf(1'b1, 4'b1100, 1'b1), 4'd1); chk("R3", "ORRS mask", fw, 2);
    drive(2'b00, dpf(1'b1, 4'b0001, 1'b1), 4'd1); chk("R3", "EORS mask", fw, 2);
  endtask

  task automatic t_loads;
    drive(2'b01, mf(1'b0, 1'b1), 4'd6);
    chk("R4", "reg_w", rw, 1);      chk("R4", "mem_to_reg", m2r, 1);
    chk("R4", "alu_src", alu_imm, 1); chk("R4", "imm_sel", imm_sel, 1);
    chk("R4", "byte", byte_a, 0);   chk("R4", "mem_w", mw, 0);
    chk("R8", "LDR alu", ac, 0);
    drive(2'b01, mf(1'b1, 1'b1), 4'd7);
    chk("R5", "byte", byte_a, 1);   chk("R5", "reg_w", rw, 1);
    chk("R5", "mem_to_reg", m2r, 1); chk("R5", "imm_sel", imm_sel, 1);
    chk("R8", "LDRB alu", ac, 0);
    drive(2'b01, mf(1'b0, 1'b1), 4'd15);
    chk("R9", "LDR to r15 pc_src", pcs, 0);
  endtask

  task automatic t_stores;
    drive(2'b01, mf(1'b0, 1'b0), 4'd2);
    chk("R6", "mem_w", mw, 1); chk("R6", "reg_w", rw, 0);
    chk("R6", "src_m_rd", m_rd, 1); chk("R6", "imm_sel", imm_sel, 1);
    chk("R6", "alu_src", alu_imm, 1); chk("R6", "byte", byte_a, 0);
    drive(2'b01, mf(1'b1, 1'b0), 4'd2);
    chk("R6", "byte with B set", byte_a, 0); chk("R6", "mem_w B", mw, 1);
    drive(2'b01, {1'b1, 4'b0010, 1'b0}, 4'd2);
    chk("R8", "store odd bits alu", ac, 0); chk("R8", "store flags", fw, 0);
  endtask

  task automatic t_branch;
    drive(2'b10, 6'b101111, 4'd9);
    chk("R7", "pc_src", pcs, 1); chk("R7", "src_n_pc", n_pc, 1);
    chk("R7", "imm_sel", imm_sel, 2); chk("R7", "alu_src", alu_imm, 1);
    chk("R7", "reg_w", rw, 0); chk("R7", "mem_w", mw, 0);
    chk("R8", "branch alu", ac, 0); chk("R8", "branch flags", fw, 0);
  endtask

  task automatic t_pc_write;
    drive(2'b00, dpf(1'b1, 4'b0100, 1'b0), 4'd15); chk("R9", "ADD pc", pcs, 1);
    drive(2'b00, dpf(1'b0, 4'b0001, 1'b1), 4'd15); chk("R9", "EORS pc", pcs, 1);
    drive(2'b00, dpf(1'b0, 4'b0100, 1'b0), 4'd14); chk("R9", "ADD r14", pcs, 0);
  endtask

  task automatic t_unsupported;
    drive(2'b00, dpf(1'b0, 4'b1010, 1'b1), 4'd15);
    chk("R10", "bad cmd reg_w", rw, 0); chk("R10", "bad cmd flags", fw, 0);
    chk("R10", "bad cmd pc_src", pcs, 0); chk("R10", "bad cmd mem_w", mw, 0);
    drive(2'b11, 6'b000001, 4'd0);
    chk("R10", "rsv reg_w", rw, 0); chk("R10", "rsv mem_w", mw, 0);
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    op = 2'b11; fn = '0; rd = '0;
    t_reset_state();
    t_dp_ops();
    t_flags();
    t_loads();
    t_stores();
    t_branch();
    t_pc_write();
    t_unsupported();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule